// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

The block gathers interrupt request lines into priority levels. There is one internal level, a configurable number of external levels (six by default) and one trace level. Each clock it picks the highest-priority level that has a pending request, is not masked, and ranks strictly above every level that is already being serviced. It then raises `irq` together with that level's fixed vector address. The processor accepts the interrupt with a one-cycle `ack`, which marks the level active.

Active levels nest. Each active level holds off requests on its own level and on all lower levels until the processor retires it with a one-cycle `brout` (branch out of interrupts). Each `brout` retires only the highest-priority active level, so the level that was interrupted resumes.

Every level except trace has a status word, one bit per request line, that software reads through a level-indexed read port. While a level is active, any line that asserts on it is captured and stays visible until that level is retired. A channel check error pulse sets a dedicated bit in the internal level's status word, and that bit makes the internal level pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Priority runs from the internal level (index 0, highest), through external levels 0..N_EXT-1 (indices 1..N_EXT, lower number wins), to the trace level (index N_EXT+1, lowest). `irq` presents the highest-priority eligible level.
- R2: The vector address is 8 for the internal level, 9 for the trace level and 11+n for external level n. `vec` reads 0 while `irq` is low.
- R3: A set bit `mask[n]` (1 = masked) stops external level n from being presented. The internal and trace levels ignore the mask.
- R4: `rd_word` returns the status word of the level at index `rd_lvl`, where bit i is request line i. The value is the OR of the live lines and the lines captured while that level is active. Captured bits persist after a line withdraws until that level is retired. For the trace index or any index above it, `rd_word` reads 0.
- R5: A one-cycle `chan_err` pulse sets bit 4 of the internal status word. The bit stays set until the internal level is retired, and it makes the internal level pending.
- R6: While levels are active, only a level of strictly higher priority than the highest active level can be presented. The same level and lower levels are held off.
- R7: On a clock edge with `ack` and `irq` both high, the active bit of the presented level is set. `ack` with `irq` low changes nothing.
- R8: On a clock edge with `brout` high, only the highest-priority active bit is cleared, and that level's captured status bits are dropped. With no level active, `brout` has no effect.
- R9: `irq` and `vec` are registered. They reflect the inputs and active state one clock edge after a change.
- R10: After reset, `active` is all zero, `irq` is low and every status word reads 0 with no lines asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_req | input | LINES | Request lines of the internal level |
| ext_req | input | N_EXT*LINES | Request lines of the external levels, level n in bits n*LINES +: LINES |
| trace_req | input | 1 | Trace level request |
| chan_err | input | 1 | Channel check error pulse, sets internal status bit 4 |
| mask | input | N_EXT | Mask per external level, 1 = masked |
| ack | input | 1 | Processor accepts the presented level |
| brout | input | 1 | Branch out of interrupts, retires the highest active level |
| rd_lvl | input | IW | Level index for the status read port |
| rd_word | output | LINES | Status word of level `rd_lvl` |
| irq | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector address of the presented level |
| active | output | N_EXT+2 | Active level bits, by priority index |

## Verification
Nesting is the central corner. The bench stacks three levels, then retires them one by one while a lower request is held. A design that cleared the wrong bit, or every bit, on `brout` would present that held request too early. Same-level and lower-level requests are raised while a level is active, to catch a design that compares with "at or above" where it should use "strictly above". It would re-interrupt itself.

Requests are also withdrawn and raised on an active level. A design that did not capture them would lose status bits that software still has to read. The mask is tried against the internal and trace levels, which a naive mask would silence. The channel error pulse is checked for persistence until the internal level is retired.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

    localparam int VEC_W   = 8;
    localparam int CHK_BIT = 4;

    // Vector address for a level given by priority index.
    function automatic logic [VEC_W-1:0] lvl_vector(input int idx, input int nlvl);
        if (idx == 0)
            return VEC_W'(8);
        else if (idx == nlvl - 1)
            return VEC_W'(9);
        else
            return VEC_W'(10 + idx);
    endfunction

endpackage

// File: rtl/ilc_prio_pick.sv
module ilc_prio_pick #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Lowest set index wins (index 0 is highest priority).
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ilc_status_bank.sv
module ilc_status_bank
    import ilc_pkg::*;
#(
    parameter int NST   = 7,
    parameter int LINES = 16,
    parameter int IW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NST*LINES-1:0] lines,
    input  logic [NST-1:0]       act_nxt,
    input  logic                 chk_err,
    input  logic                 clr_en,
    input  logic [IW-1:0]        clr_idx,
    output logic [NST*LINES-1:0] words_now,
    output logic [NST*LINES-1:0] words_nxt
);

    logic [NST-1:0][LINES-1:0] cap_d, cap_q;

    always_comb begin
        for (int i = 0; i < NST; i++) begin
            if (clr_en && (int'(clr_idx) == i))
                cap_d[i] = '0;
            else
                cap_d[i] = cap_q[i] | (act_nxt[i] ? lines[i*LINES +: LINES] : '0);
        end
        cap_d[0][CHK_BIT] = cap_d[0][CHK_BIT] | chk_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    generate
        for (genvar g = 0; g < NST; g++) begin : g_word
            assign words_now[g*LINES +: LINES] = cap_q[g] | lines[g*LINES +: LINES];
            assign words_nxt[g*LINES +: LINES] = cap_d[g] | lines[g*LINES +: LINES];
        end
    endgenerate

    // R5
    chk_bit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_err |=> cap_q[0][CHK_BIT]);

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import ilc_pkg::*;
#(
    parameter  int N_EXT = 6,
    parameter  int LINES = 16,
    localparam int NLVL  = N_EXT + 2,
    localparam int NST   = N_EXT + 1,
    localparam int IW    = $clog2(NLVL)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LINES-1:0]       int_req,
    input  logic [N_EXT*LINES-1:0] ext_req,
    input  logic                   trace_req,
    input  logic                   chan_err,
    input  logic [N_EXT-1:0]       mask,
    input  logic                   ack,
    input  logic                   brout,
    input  logic [IW-1:0]          rd_lvl,
    output logic [LINES-1:0]       rd_word,
    output logic                   irq,
    output logic [VEC_W-1:0]       vec,
    output logic [NLVL-1:0]        active
);

    typedef struct packed {
        logic [NLVL-1:0] act;
        logic            irq;
        logic [IW-1:0]   sel;
    } ctl_t;

    ctl_t s_d, s_q;

    logic [NST*LINES-1:0] all_lines;
    logic [NST*LINES-1:0] words_now, words_nxt;
    logic [NLVL-1:0]      act_nxt, pend, enab, above, elig;
    logic                 top_found, ntop_found, cand_found;
    logic [IW-1:0]        top_idx, ntop_idx, cand_idx;
    logic                 clr_en;

    assign all_lines = {ext_req, int_req};
    assign enab      = {1'b1, ~mask, 1'b1};

    // Highest active level, as registered.
    ilc_prio_pick #(.W(NLVL), .IW(IW)) u_top (
        .req   (s_q.act),
        .found (top_found),
        .idx   (top_idx)
    );

    assign clr_en = brout && top_found;

    // Active vector after this edge's branch-out and acknowledge.
    always_comb begin
        act_nxt = s_q.act;
        if (clr_en)
            act_nxt[top_idx] = 1'b0;
        if (ack && s_q.irq)
            act_nxt[s_q.sel] = 1'b1;
    end

    ilc_status_bank #(.NST(NST), .LINES(LINES), .IW(IW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines     (all_lines),
        .act_nxt   (act_nxt[NST-1:0]),
        .chk_err   (chan_err),
        .clr_en    (clr_en),
        .clr_idx   (top_idx),
        .words_now (words_now),
        .words_nxt (words_nxt)
    );

    generate
        for (genvar g = 0; g < NST; g++) begin : g_pend
            assign pend[g] = |words_nxt[g*LINES +: LINES];
        end
    endgenerate
    assign pend[NLVL-1] = trace_req;

    // Highest active level after this edge.
    ilc_prio_pick #(.W(NLVL), .IW(IW)) u_ntop (
        .req   (act_nxt),
        .found (ntop_found),
        .idx   (ntop_idx)
    );

    generate
        for (genvar g = 0; g < NLVL; g++) begin : g_above
            assign above[g] = !ntop_found || (g < int'(ntop_idx));
        end
    endgenerate

    assign elig = pend & enab & above;

    ilc_prio_pick #(.W(NLVL), .IW(IW)) u_cand (
        .req   (elig),
        .found (cand_found),
        .idx   (cand_idx)
    );

    always_comb begin
        s_d     = s_q;
        s_d.act = act_nxt;
        s_d.irq = cand_found;
        s_d.sel = cand_found ? cand_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign irq     = s_q.irq;
    assign vec     = s_q.irq ? lvl_vector(int'(s_q.sel), NLVL) : '0;
    assign active  = s_q.act;
    assign rd_word = (int'(rd_lvl) < NST) ? words_now[int'(rd_lvl)*LINES +: LINES] : '0;

    // R7
    ack_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && s_q.irq && !brout) |=> ($countones(s_q.act) == $countones($past(s_q.act)) + 1));

    // R8
    brout_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brout && !ack && (s_q.act != '0)) |=> ($countones(s_q.act) == $countones($past(s_q.act)) - 1));

    // R6
    preempt_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.irq && top_found) |-> (s_q.sel < top_idx));

    generate
        for (genvar n = 0; n < N_EXT; n++) begin : g_mask_chk
            // R3
            masked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                mask[n] |=> !(s_q.irq && (s_q.sel == IW'(n + 1))));
        end
    endgenerate

endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;

    localparam int N_EXT = 6;
    localparam int LINES = 16;
    localparam int NLVL  = N_EXT + 2;
    localparam int IW    = $clog2(NLVL);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [LINES-1:0]       int_req = '0;
    logic [N_EXT*LINES-1:0] ext_req = '0;
    logic                   trace_req = 1'b0;
    logic                   chan_err = 1'b0;
    logic [N_EXT-1:0]       mask = '0;
    logic                   ack = 1'b0;
    logic                   brout = 1'b0;
    logic [IW-1:0]          rd_lvl = '0;
    logic [LINES-1:0]       rd_word;
    logic                   irq;
    logic [7:0]             vec;
    logic [NLVL-1:0]        active;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.N_EXT(N_EXT), .LINES(LINES)) u_prio_irq_ctrl (
        .clk, .rst_n, .int_req, .ext_req, .trace_req, .chan_err, .mask,
        .ack, .brout, .rd_lvl, .rd_word, .irq, .vec, .active
    );

    // {int, ext[5:0], trace, mask[5:0], exp_irq, exp_vec[7:0]}
    localparam logic [22:0] TBL [10] = '{
        {1'b0, 6'b000000, 1'b0, 6'b000000, 1'b0, 8'd0 },
        {1'b0, 6'b000100, 1'b0, 6'b000000, 1'b1, 8'd13},
        {1'b0, 6'b100101, 1'b0, 6'b000000, 1'b1, 8'd11},
        {1'b0, 6'b000101, 1'b0, 6'b000001, 1'b1, 8'd13},
        {1'b0, 6'b000000, 1'b1, 6'b111111, 1'b1, 8'd9 },
        {1'b1, 6'b111111, 1'b1, 6'b000000, 1'b1, 8'd8 },
        {1'b1, 6'b000000, 1'b0, 6'b111111, 1'b1, 8'd8 },
        {1'b0, 6'b111111, 1'b0, 6'b111111, 1'b0, 8'd0 },
        {1'b0, 6'b100000, 1'b1, 6'b011111, 1'b1, 8'd16},
        {1'b0, 6'b001000, 1'b1, 6'b000000, 1'b1, 8'd14}
    };

    task automatic check(input string req, input string what, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_brout();
        brout = 1'b1; tick(); brout = 1'b0;
    endtask

    task automatic set_ext(input int n, input logic [LINES-1:0] w);
        ext_req[n*LINES +: LINES] = w;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset: R10
        repeat (3) tick();
        check("R10", "irq in reset", 32'(irq), 0);
        check("R10", "active in reset", 32'(active), 0);
        rst_n = 1'b1;
        tick();
        check("R10", "irq after reset", 32'(irq), 0);
        check("R10", "active after reset", 32'(active), 0);
        check("R10", "vec after reset", 32'(vec), 0);
        rd_lvl = 0;
        check("R10", "status word", 32'(rd_word), 0);

        // Vector table: R1 R2 R3 R9
        for (int k = 0; k < 10; k++) begin
            int_req   = {15'b0, TBL[k][22]};
            for (int n = 0; n < N_EXT; n++)
                set_ext(n, {15'b0, TBL[k][16+n]});
            trace_req = TBL[k][15];
            mask      = TBL[k][14:9];
            tick();
            check("R1/R3", $sformatf("row %0d irq", k), 32'(irq), 32'(TBL[k][8]));
            check("R2", $sformatf("row %0d vec", k), 32'(vec), 32'(TBL[k][7:0]));
            check("R10", $sformatf("row %0d active", k), 32'(active), 0);
        end
        int_req = '0; ext_req = '0; trace_req = 1'b0; mask = '0;
        tick();
        check("R9", "idle irq", 32'(irq), 0);

        // R9: registered output, one edge of latency
        set_ext(3, 16'h0001);
        #1 check("R9", "irq before edge", 32'(irq), 0);
        tick();
        check("R9", "irq after edge", 32'(irq), 1);
        set_ext(3, 16'h0000);
        tick();

        // R7: ack without irq ignored
        check("R7", "irq low before ack", 32'(irq), 0);
        pulse_ack();
        check("R7", "ack w/o irq", 32'(active), 0);

        // Nesting: R6 R7 R8
        set_ext(2, 16'h0001);
        tick();
        check("R6", "ext2 vec", 32'(vec), 13);
        pulse_ack();
        check("R7", "ext2 active", 32'(active), 32'h08);
        check("R6", "ext2 held off", 32'(irq), 0);
        set_ext(4, 16'h0001);
        tick();
        check("R6", "lower held off", 32'(irq), 0);
        set_ext(0, 16'h0001);
        tick();
        check("R6", "higher preempts irq", 32'(irq), 1);
        check("R6", "higher preempts vec", 32'(vec), 11);
        pulse_ack();
        check("R7", "two active", 32'(active), 32'h0A);
        int_req = 16'h0001;
        tick();
        check("R6", "internal vec", 32'(vec), 8);
        pulse_ack();
        check("R7", "three active", 32'(active), 32'h0B);
        int_req = '0; set_ext(0, 16'h0); set_ext(2, 16'h0);
        pulse_brout();
        check("R8", "retire internal", 32'(active), 32'h0A);
        tick();
        check("R8", "no irq after first retire", 32'(irq), 0);
        pulse_brout();
        check("R8", "retire ext0", 32'(active), 32'h08);
        tick();
        check("R8", "ext4 still held", 32'(irq), 0);
        pulse_brout();
        check("R8", "retire ext2", 32'(active), 0);
        tick();
        check("R8", "ext4 presented", 32'(vec), 15);
        set_ext(4, 16'h0);
        tick();
        check("R8", "idle again", 32'(irq), 0);
        pulse_brout();
        check("R8", "brout with none active", 32'(active), 0);

        // Status words: R4
        rd_lvl = 2;
        set_ext(1, 16'h0A05);
        tick();
        check("R4", "live word", 32'(rd_word), 32'h0A05);
        check("R2", "ext1 vec", 32'(vec), 12);
        pulse_ack();
        check("R4", "ext1 active", 32'(active), 32'h04);
        set_ext(1, 16'h0040);
        tick();
        check("R4", "captured plus new", 32'(rd_word), 32'h0A45);
        set_ext(1, 16'h0000);
        tick();
        check("R4", "captured after withdraw", 32'(rd_word), 32'h0A45);
        set_ext(1, 16'h0001);
        pulse_brout();
        check("R4", "cleared on retire", 32'(rd_word), 32'h0001);
        check("R4", "re-presented", 32'(vec), 12);
        set_ext(1, 16'h0000);
        rd_lvl = IW'(NLVL - 1);
        trace_req = 1'b1;
        tick();
        check("R4", "trace reads zero", 32'(rd_word), 0);
        trace_req = 1'b0;
        tick();

        // Channel check error: R5
        rd_lvl = 0;
        chan_err = 1'b1; tick(); chan_err = 1'b0;
        check("R5", "status bit 4", 32'(rd_word), 32'h0010);
        check("R5", "internal vec", 32'(vec), 8);
        pulse_ack();
        check("R5", "internal active", 32'(active), 32'h01);
        check("R5", "bit 4 held", 32'(rd_word), 32'h0010);
        pulse_brout();
        check("R5", "bit 4 cleared", 32'(rd_word), 0);
        check("R5", "no irq", 32'(irq), 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule